// File: doc/BRIEF.md
# Reset Event Recorder with Escalation

This block logs why the device was reset and decides how severe the next reset must be. Functional reset sources and destructive reset sources each set a sticky flag in their own status register. Software reads the flags and clears them by writing ones. A flag whose source is still active sets again at once, so software keeps writing the value back until it reads zero.

Every functional event that is not diverted raises a functional-reset request. The request is held until the reset sequencer acknowledges entry. Two saturating counters track how many functional and destructive resets have occurred since they were last rearmed. When the functional count has reached its programmed limit, the next functional event becomes a destructive reset. When the destructive count has reached its limit, the device is locked in reset until the next power-on. A functional request that is not acknowledged within a programmable number of cycles is also escalated to a destructive reset.

Selected functional sources can be diverted through a write-once diversion register. A diverted source raises an interrupt line instead of a reset request.

Top module: `reset_event_ctrl`

## Requirements
- R1: Bit i of the functional status register (address 0) and bit i of the destructive status register (address 1) stay at 1 until a bus write to that address carries a 1 in bit i. Writing 0 to a set bit leaves it set.
- R2: If a source is active in the same cycle as a write that clears its flag, the flag stays set.
- R3: At power-on the destructive status register reads 1 (bit 0 is the power-on flag) and every other status bit reads 0. The counters (address 6: destructive count in bits 7:4, functional count in bits 3:0), the thresholds and the diversion register read 0. All outputs are low.
- R4: Each byte of the diversion register (address 2) accepts only the first write that has its byte enable set after power-on. Only source bits 0 and 8 can be stored; every other bit reads 0.
- R5: A functional event whose source bit is set in the diversion register raises no functional-reset request. alt_irq is high while any status bit is set together with its diversion bit.
- R6: A functional event that is not diverted raises func_rst_req in the next cycle and increments the functional count. The request is held until entry_done.
- R7: With a nonzero functional threshold (address 3), a functional event that arrives while the count is at or above the threshold produces a one-cycle dest_rst_req instead. It also sets destructive status bit 1 and clears the functional count.
- R8: A pulse on dest_evt[j] sets destructive status bit j+2 and produces a one-cycle dest_rst_req. It drops any pending functional request, clears the functional count and increments the destructive count.
- R9: With a nonzero destructive threshold (address 4), a destructive reset that occurs while the destructive count is at or above the threshold sets dev_lock. dev_lock stays high until power-on.
- R10: The functional threshold accepts one write after power-on or after any destructive reset. The destructive threshold accepts one write after power-on only. Later writes are ignored.
- R11: With a nonzero entry timeout T (address 5), a functional request still held without entry_done T+1 cycles after it rose is dropped. A one-cycle dest_rst_req follows in the next cycle, and destructive status bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| func_evt | input | NF | Functional source event pulses |
| dest_evt | input | ND | Destructive source event pulses |
| entry_done | input | 1 | Functional-reset entry acknowledge |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_be | input | DW/8 | Byte enables, used by the diversion register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, combinational |
| func_rst_req | output | 1 | Functional-reset request level |
| dest_rst_req | output | 1 | Destructive-reset request pulse |
| alt_irq | output | 1 | Interrupt for diverted functional events |
| dev_lock | output | 1 | Held-in-reset indication until power-on |

## Verification
The properties assume that event inputs and bus writes change only between clock edges. They also assume that entry_done arrives only while a functional request is pending. The stimulus meets both conditions by driving every input on the falling edge and by pulsing entry_done only after a request has been seen. The randomized phase mixes sparse source pulses with clearing writes to the functional status register. A functional request may time out during this phase; the properties allow for that case rather than excluding it.

// File: rtl/rec_pkg.sv
package rec_pkg;
  typedef enum logic [2:0] {
    RA_FSTAT = 3'd0,
    RA_DSTAT = 3'd1,
    RA_FDIS  = 3'd2,
    RA_FTHR  = 3'd3,
    RA_DTHR  = 3'd4,
    RA_TMO   = 3'd5,
    RA_CNT   = 3'd6,
    RA_NONE  = 3'd7
  } reg_addr_e;

  localparam int DST_POR = 0;
  localparam int DST_ESC = 1;
  localparam int DST_SRC = 2;
endpackage

// File: rtl/rec_sticky.sv
module rec_sticky #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  // set dominates clear so an active source reasserts immediately
  function automatic logic [W-1:0] next_flags(input logic [W-1:0] cur,
                                              input logic [W-1:0] clr,
                                              input logic [W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) stat_o <= RST_VAL;
    else        stat_o <= next_flags(stat_o, clr_i, set_i);
  end
endmodule

// File: rtl/rec_wonce.sv
module rec_wonce #(
  parameter int            DW        = 16,
  parameter logic [DW-1:0] KEEP_MASK = '1
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            we_i,
  input  logic [DW/8-1:0] be_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   q_o
);
  localparam int NB = DW / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic used_q;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        used_q        <= 1'b0;
        q_o[b*8 +: 8] <= '0;
      end else if (we_i && be_i[b] && !used_q) begin
        used_q        <= 1'b1;
        q_o[b*8 +: 8] <= wdata_i[b*8 +: 8] & KEEP_MASK[b*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/rec_escal.sv
module rec_escal #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          f_take_i,
  input  logic          d_occ_i,
  input  logic          fthr_we_i,
  input  logic          dthr_we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] fthr_o,
  output logic [CW-1:0] dthr_o,
  output logic [CW-1:0] fcnt_o,
  output logic [CW-1:0] dcnt_o,
  output logic          f_hit_o,
  output logic          lock_o
);
  function automatic logic reached(input logic [CW-1:0] cnt, input logic [CW-1:0] thr);
    return (thr != '0) && (cnt >= thr);
  endfunction

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] cnt);
    return (cnt == '1) ? cnt : cnt + 1'b1;
  endfunction

  logic fopen_q, dopen_q, d_hit;

  assign f_hit_o = reached(fcnt_o, fthr_o);
  assign d_hit   = reached(dcnt_o, dthr_o);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fthr_o  <= '0;
      dthr_o  <= '0;
      fcnt_o  <= '0;
      dcnt_o  <= '0;
      lock_o  <= 1'b0;
      fopen_q <= 1'b1;
      dopen_q <= 1'b1;
    end else begin
      if (fthr_we_i && fopen_q) begin
        fthr_o  <= wdata_i;
        fopen_q <= 1'b0;
      end
      if (d_occ_i) fopen_q <= 1'b1;
      if (dthr_we_i && dopen_q) begin
        dthr_o  <= wdata_i;
        dopen_q <= 1'b0;
      end
      if (d_occ_i) begin
        fcnt_o <= '0;
        if (d_hit) lock_o <= 1'b1;
        else       dcnt_o <= bump(dcnt_o);
      end else if (f_take_i) begin
        fcnt_o <= bump(fcnt_o);
      end
    end
  end
endmodule

// File: rtl/reset_event_ctrl.sv
module reset_event_ctrl
  import rec_pkg::*;
#(
  parameter int            DW           = 16,
  parameter int            NF           = 16,
  parameter int            ND           = 6,
  parameter int            CW           = 4,
  parameter int            TW           = 8,
  parameter logic [DW-1:0] IRQ_SRC_MASK = 16'h0101
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [NF-1:0]   func_evt,
  input  logic [ND-1:0]   dest_evt,
  input  logic            entry_done,
  input  logic            bus_we,
  input  logic [2:0]      bus_addr,
  input  logic [DW/8-1:0] bus_be,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            func_rst_req,
  output logic            dest_rst_req,
  output logic            alt_irq,
  output logic            dev_lock
);
  localparam int DSW = ND + DST_SRC;

  // named internal events
  logic [NF-1:0]  fstat;
  logic [DSW-1:0] dstat;
  logic [DW-1:0]  fdis_q;
  logic [NF-1:0]  fdis_eff;
  logic [CW-1:0]  fthr, dthr, fcnt, dcnt;
  logic [TW-1:0]  tmo_q, ent_cnt;
  logic           f_hit, f_occ, f_esc, f_take, tmo_hit, d_occ;
  logic           wr_fstat, wr_dstat, wr_fdis, wr_fthr, wr_dthr, wr_tmo;
  logic [DSW-1:0] dset;

  assign wr_fstat = bus_we && (bus_addr == RA_FSTAT);
  assign wr_dstat = bus_we && (bus_addr == RA_DSTAT);
  assign wr_fdis  = bus_we && (bus_addr == RA_FDIS);
  assign wr_fthr  = bus_we && (bus_addr == RA_FTHR);
  assign wr_dthr  = bus_we && (bus_addr == RA_DTHR);
  assign wr_tmo   = bus_we && (bus_addr == RA_TMO);

  assign fdis_eff = fdis_q[NF-1:0];
  assign f_occ    = |(func_evt & ~fdis_eff);
  assign f_esc    = f_occ && f_hit;
  assign tmo_hit  = func_rst_req && !entry_done && (tmo_q != '0) && (ent_cnt == tmo_q);
  assign d_occ    = (|dest_evt) || f_esc || tmo_hit;
  assign f_take   = f_occ && !d_occ;
  assign dset     = {dest_evt, (f_esc || tmo_hit), 1'b0};
  assign alt_irq  = |(fstat & fdis_eff);

  rec_sticky #(.W(NF), .RST_VAL('0)) u_fstat (
    .clk(clk), .por_n(por_n), .set_i(func_evt),
    .clr_i(wr_fstat ? bus_wdata[NF-1:0] : '0), .stat_o(fstat)
  );

  rec_sticky #(.W(DSW), .RST_VAL(DSW'(1))) u_dstat (
    .clk(clk), .por_n(por_n), .set_i(dset),
    .clr_i(wr_dstat ? bus_wdata[DSW-1:0] : '0), .stat_o(dstat)
  );

  rec_wonce #(.DW(DW), .KEEP_MASK(IRQ_SRC_MASK)) u_fdis (
    .clk(clk), .por_n(por_n), .we_i(wr_fdis), .be_i(bus_be),
    .wdata_i(bus_wdata), .q_o(fdis_q)
  );

  rec_escal #(.CW(CW)) u_escal (
    .clk(clk), .por_n(por_n), .f_take_i(f_take), .d_occ_i(d_occ),
    .fthr_we_i(wr_fthr), .dthr_we_i(wr_dthr), .wdata_i(bus_wdata[CW-1:0]),
    .fthr_o(fthr), .dthr_o(dthr), .fcnt_o(fcnt), .dcnt_o(dcnt),
    .f_hit_o(f_hit), .lock_o(dev_lock)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      func_rst_req <= 1'b0;
      dest_rst_req <= 1'b0;
      ent_cnt      <= '0;
      tmo_q        <= '0;
    end else begin
      dest_rst_req <= d_occ;
      if (wr_tmo) tmo_q <= bus_wdata[TW-1:0];
      if (d_occ)           func_rst_req <= 1'b0;
      else if (f_take)     func_rst_req <= 1'b1;
      else if (entry_done) func_rst_req <= 1'b0;
      if (!func_rst_req || d_occ || f_take || entry_done) ent_cnt <= '0;
      else                                                ent_cnt <= ent_cnt + 1'b1;
    end
  end

  always_comb begin
    unique case (bus_addr)
      RA_FSTAT: bus_rdata = DW'(fstat);
      RA_DSTAT: bus_rdata = DW'(dstat);
      RA_FDIS:  bus_rdata = fdis_q;
      RA_FTHR:  bus_rdata = DW'(fthr);
      RA_DTHR:  bus_rdata = DW'(dthr);
      RA_TMO:   bus_rdata = DW'(tmo_q);
      RA_CNT:   bus_rdata = DW'({dcnt, fcnt});
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rec_checker.sv
module rec_checker #(
  parameter int NF = 16,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          por_n,
  input logic          bus_we,
  input logic [2:0]    bus_addr,
  input logic [NF-1:0] func_evt,
  input logic [NF-1:0] fstat,
  input logic [NF-1:0] fdis_eff,
  input logic          func_rst_req,
  input logic          dest_rst_req,
  input logic          dev_lock,
  input logic          tmo_hit,
  input logic [CW-1:0] fcnt,
  input logic [CW-1:0] dcnt
);
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !(bus_we && bus_addr == 3'd0) |=> ((fstat & $past(fstat)) == $past(fstat))); // R1
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!por_n)
    (func_evt != '0) |=> ((fstat & $past(func_evt)) == $past(func_evt))); // R2
  AST_DIVERTED_NO_REQ: assert property (@(posedge clk) disable iff (!por_n)
    ((func_evt != '0) && ((func_evt & ~fdis_eff) == '0) && !func_rst_req) |=> !func_rst_req); // R5
  AST_FCNT_CLEARED: assert property (@(posedge clk) disable iff (!por_n)
    dest_rst_req |-> (fcnt == '0)); // R7
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!por_n)
    !(dest_rst_req && func_rst_req)); // R8
  AST_DCNT_NO_DROP: assert property (@(posedge clk) disable iff (!por_n)
    dest_rst_req |=> (dcnt >= $past(dcnt))); // R8
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    dev_lock |=> dev_lock); // R9
  AST_TIMEOUT_ESC: assert property (@(posedge clk) disable iff (!por_n)
    tmo_hit |=> (dest_rst_req && !func_rst_req)); // R11
endmodule

bind reset_event_ctrl rec_checker #(.NF(NF), .CW(CW)) u_chk (
  .clk(clk), .por_n(por_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .func_evt(func_evt), .fstat(fstat), .fdis_eff(fdis_eff),
  .func_rst_req(func_rst_req), .dest_rst_req(dest_rst_req),
  .dev_lock(dev_lock), .tmo_hit(tmo_hit), .fcnt(fcnt), .dcnt(dcnt)
);

// File: tb/tb_reset_event_ctrl.sv
module tb_reset_event_ctrl;
  localparam int CLK_PER = 10;
  localparam int DW = 16, NF = 16, ND = 6;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic [NF-1:0] func_evt = '0;
  logic [ND-1:0] dest_evt = '0;
  logic          entry_done = 1'b0;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [1:0]    bus_be = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          func_rst_req, dest_rst_req, alt_irq, dev_lock;

  int checks = 0;
  int errors = 0;

  reset_event_ctrl dut (
    .clk(clk), .por_n(por_n), .func_evt(func_evt), .dest_evt(dest_evt),
    .entry_done(entry_done), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .func_rst_req(func_rst_req),
    .dest_rst_req(dest_rst_req), .alt_irq(alt_irq), .dev_lock(dev_lock)
  );

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [15:0] w1c_model(input logic [15:0] cur, input logic [15:0] clr,
                                            input logic [15:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [15:0] cnt_word(input int dc, input int fc);
    return 16'((dc << 4) | fc);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d, input logic [1:0] be);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic pulse_f(input logic [NF-1:0] v);
    @(negedge clk);
    func_evt = v;
    @(negedge clk);
    func_evt = '0;
    #1;
  endtask

  task automatic pulse_d(input logic [ND-1:0] v);
    @(negedge clk);
    dest_evt = v;
    @(negedge clk);
    dest_evt = '0;
    #1;
  endtask

  task automatic ack();
    @(negedge clk);
    entry_done = 1'b1;
    @(negedge clk);
    entry_done = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_PER * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [15:0] model;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    por_n = 1'b1;

    // R3 power-on state
    rd(3'd1, d); chk("R3 dstat", d, 16'h0001);
    rd(3'd0, d); chk("R3 fstat", d, 16'h0000);
    rd(3'd6, d); chk("R3 counts", d, 16'h0000);
    rd(3'd2, d); chk("R3 fdis", d, 16'h0000);
    chk("R3 outputs", {func_rst_req, dest_rst_req, alt_irq, dev_lock}, 4'b0000);

    // R1 write-one-to-clear
    wr(3'd1, 16'h0000, 2'b11);
    rd(3'd1, d); chk("R1 zero write keeps flag", d, 16'h0001);
    wr(3'd1, 16'h0001, 2'b11);
    rd(3'd1, d); chk("R1 one write clears", d, 16'h0000);

    // R10 threshold write windows
    wr(3'd3, 16'd2, 2'b11); wr(3'd3, 16'd5, 2'b11);
    rd(3'd3, d); chk("R10 fthr once", d, 16'd2);
    wr(3'd4, 16'd2, 2'b11); wr(3'd4, 16'd7, 2'b11);
    rd(3'd4, d); chk("R10 dthr once", d, 16'd2);

    // R4 write-once per byte, only bits 0 and 8 storable
    wr(3'd2, 16'hFFFF, 2'b01);
    rd(3'd2, d); chk("R4 byte0 masked", d, 16'h0001);
    wr(3'd2, 16'hFFFF, 2'b11);
    rd(3'd2, d); chk("R4 byte1 first", d, 16'h0101);
    wr(3'd2, 16'h0000, 2'b11);
    rd(3'd2, d); chk("R4 relock", d, 16'h0101);

    // R5 diverted source
    pulse_f(16'h0001);
    chk("R5 no request", func_rst_req, 1'b0);
    chk("R5 irq", alt_irq, 1'b1);
    wr(3'd0, 16'h0001, 2'b11);
    #1 chk("R5 irq cleared", alt_irq, 1'b0);

    // R6 functional request held until ack
    pulse_f(16'h0004);
    chk("R6 request", func_rst_req, 1'b1);
    repeat (4) @(negedge clk);
    #1 chk("R6 held", func_rst_req, 1'b1);
    rd(3'd6, d); chk("R6 fcnt", d, cnt_word(0, 1));
    ack();
    chk("R6 released", func_rst_req, 1'b0);
    pulse_f(16'h0008); ack();

    // R7 escalation at functional threshold 2
    pulse_f(16'h0010);
    chk("R7 dest pulse", dest_rst_req, 1'b1);
    chk("R7 no func req", func_rst_req, 1'b0);
    rd(3'd1, d); chk("R7 dstat esc bit", d, 16'h0002);
    rd(3'd6, d); chk("R7 counts", d, cnt_word(1, 0));

    // R10 functional window reopened by destructive reset
    wr(3'd3, 16'd3, 2'b11);
    rd(3'd3, d); chk("R10 fthr reopened", d, 16'd3);

    // R8 destructive source drops pending request
    pulse_f(16'h0080);
    chk("R8 pending", func_rst_req, 1'b1);
    pulse_d(6'b000001);
    chk("R8 dest pulse", dest_rst_req, 1'b1);
    chk("R8 req dropped", func_rst_req, 1'b0);
    rd(3'd1, d); chk("R8 dstat src bit", d, 16'h0006);
    rd(3'd6, d); chk("R8 counts", d, cnt_word(2, 0));
    chk("R9 not yet locked", dev_lock, 1'b0);

    // R9 lock at destructive threshold
    pulse_d(6'b000010);
    chk("R9 lock", dev_lock, 1'b1);
    rd(3'd6, d); chk("R9 dcnt held", d, cnt_word(2, 0));
    repeat (3) @(negedge clk);
    #1 chk("R9 lock sticky", dev_lock, 1'b1);

    // R11 entry timeout of 3
    wr(3'd1, 16'h00FF, 2'b11);
    wr(3'd5, 16'd3, 2'b11);
    pulse_f(16'h0020);
    chk("R11 request", func_rst_req, 1'b1);
    repeat (3) @(negedge clk);
    #1 chk("R11 still waiting", {func_rst_req, dest_rst_req}, 2'b10);
    @(negedge clk);
    #1 chk("R11 escalated", {func_rst_req, dest_rst_req}, 2'b01);
    rd(3'd1, d); chk("R11 dstat esc bit", d, 16'h0002);

    // R2 set dominates simultaneous clear
    @(negedge clk);
    func_evt = 16'h0040; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0040;
    @(negedge clk);
    func_evt = '0; bus_we = 1'b0;
    rd(3'd0, d); chk("R2 reassert", d[6], 1'b1);
    ack();

    // R1 R2 random phase on functional status
    wr(3'd0, 16'hFFFF, 2'b11);
    model = '0;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] ev, cl;
      logic        w;
      @(negedge clk);
      ev = ($urandom % 4 == 0) ? 16'(1 << ($urandom % 16)) : 16'h0000;
      w  = ($urandom % 3 == 0);
      cl = 16'($urandom);
      func_evt = ev; bus_we = w; bus_addr = 3'd0; bus_wdata = cl;
      entry_done = ($urandom % 2 == 0) && func_rst_req;
      model = w1c_model(model, w ? cl : 16'h0000, ev);
      @(negedge clk);
      func_evt = '0; bus_we = 1'b0; entry_done = 1'b0;
      #1 chk("R1 R2 random fstat", bus_rdata, model);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule